// File: doc/BRIEF.md
# Pulse-Per-Second Phase Detector

This block measures how far an external once-per-second reference pulse sits from the locally generated once-per-second pulse. It counts cycles of a fast clock taken from the oscillator being disciplined. At the default 100 MHz, one count is 10 ns. For each reference pulse it produces one signed error word, and a loop filter or host reads that word to steer the oscillator. A positive word means the reference pulse came later than the local pulse. A negative word means it came earlier. The measurement wraps at half a period, so the result always names the nearer local pulse.

A two-bit select chooses the discipline mode: free running, locked to a 5/10 MHz frequency reference, or locked to the pulse reference. Error words are produced only in the pulse-lock mode. In the other two modes the last word stays on the output unchanged. A registered copy of the mode in force is reported back. A watchdog raises a missing-pulse flag when the reference stays silent for too long.

Error words leave through a valid/ready port. A word stays on the port until `err_ready_i` accepts it. If a newer word is measured while one is still waiting, the newer word replaces it, so the consumer always receives the latest phase. With `err_ready_i` tied high, `err_valid_o` is a one-cycle strobe per measurement.

Top module: `pps_phase_detector`

## Requirements
- R1: The error word equals the signed cycle count from the latest local rise to the reference rise. A raw count `n` at or above PERIOD_TICKS/2 is reported as `n - PERIOD_TICKS`. Results therefore lie in [-(PERIOD_TICKS - PERIOD_TICKS/2), PERIOD_TICKS/2 - 1], and the local interval counter saturates at PERIOD_TICKS-1.
- R2: Both pulse inputs cross the same two-stage synchronizer. A reference rise coinciding with a local rise gives 0. The word appears three clock edges after the reference input is first sampled high.
- R3: Only mode 2'b10 (pulse lock) produces words. In 2'b01 (frequency lock), 2'b00 (free run) and 2'b11, no word is produced and `err_data_o` holds its last value.
- R4: `active_mode_o` reports the select one cycle later: 2'b00 free run, 2'b01 frequency lock, 2'b10 pulse lock. A select of 2'b11 is reported as 2'b00.
- R5: No word is produced until at least one local rise has been seen since reset.
- R6: `missing_o` rises after MISS_TICKS cycles with no reference rise, and clears on the next reference rise.
- R7: A reference rise that arrives while `missing_o` is high produces no word.
- R8: While `err_valid_o` is high and `err_ready_i` is low, valid and data hold, unless a newer word arrives. A newer word replaces the waiting one. Valid falls after acceptance unless a new word loads in that same cycle.
- R9: After reset, `err_valid_o`, `err_data_o`, `missing_o` and `active_mode_o` are all zero.
- R10: A pulse held high for many cycles counts as one edge and yields at most one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock from the disciplined oscillator |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_pps_i | input | 1 | External reference pulse, asynchronous |
| loc_pps_i | input | 1 | Local once-per-second pulse |
| mode_sel_i | input | 2 | Discipline mode select |
| err_ready_i | input | 1 | Consumer accepts the error word |
| err_valid_o | output | 1 | Error word available |
| err_data_o | output | CNT_W | Signed phase error in clock counts |
| missing_o | output | 1 | Reference pulse overdue |
| active_mode_o | output | 2 | Discipline mode in force |

## Verification
The assertions check on every cycle that reported words stay within the wrapped range. They also check that a word only ever appears after a pulse-lock cycle with a local edge seen and no missing flag. Further per-cycle checks cover the hold and retire rules of the output handshake, the one-cycle edge pulses, and how the missing flag sets and clears. Only the bench scenarios can show that the numeric error matches the placed offset across the half-period corners (0, ±1, +499, -500). The same applies to the latest-wins replacement under sustained back-pressure, to the data being held through frequency-lock and free-run windows, and to the recovery edge after a silent gap being swallowed.

// File: rtl/pps_pd_pkg.sv
package pps_pd_pkg;

  typedef enum logic [1:0] {
    MODE_FREE = 2'b00,
    MODE_FREQ = 2'b01,
    MODE_PPS  = 2'b10,
    MODE_RSVD = 2'b11
  } disc_mode_e;

  // Reserved encoding reports as free running.
  function automatic logic [1:0] report_mode(input logic [1:0] sel);
    logic [1:0] r;
    case (sel)
      MODE_FREQ: r = MODE_FREQ;
      MODE_PPS:  r = MODE_PPS;
      default:   r = MODE_FREE;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pps_edge_sync.sv
module pps_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  localparam int LAST = STAGES - 1;

  // chain[0..LAST] are synchronizer flops, chain[STAGES] keeps history.
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[LAST:0], din};
  end

  assign rise = chain[LAST] & ~chain[STAGES];

  // R10: an edge is reported for one cycle only
  a_r10_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/pps_offset_counter.sv
module pps_offset_counter #(
  parameter int CNT_W        = 28,
  parameter int PERIOD_TICKS = 100_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             loc_rise,
  output logic [CNT_W-1:0] offset,
  output logic             seen
);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(PERIOD_TICKS - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      seen <= 1'b0;
    end else begin
      if (loc_rise)        cnt <= CNT_W'(1);
      else if (cnt != SAT) cnt <= cnt + CNT_W'(1);
      if (loc_rise) seen <= 1'b1;
    end
  end

  // A local edge in the same cycle as the reference edge means zero offset.
  assign offset = loc_rise ? '0 : cnt;

  // R5: once a local edge is seen it stays seen
  a_r5_seen_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    seen |=> seen);

  // R1: interval counter never passes one period
  a_r1_counter_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= SAT);

endmodule

// File: rtl/pps_miss_watch.sv
module pps_miss_watch #(
  parameter int MISS_TICKS = 150_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_rise,
  output logic missing
);
  localparam int MW = $clog2(MISS_TICKS + 1);
  localparam logic [MW-1:0] LAST = MW'(MISS_TICKS - 1);

  logic [MW-1:0] gap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap     <= '0;
      missing <= 1'b0;
    end else if (ref_rise) begin
      gap     <= '0;
      missing <= 1'b0;
    end else if (gap == LAST) begin
      missing <= 1'b1;
    end else begin
      gap <= gap + MW'(1);
    end
  end

  // R6: a reference edge clears the flag
  a_r6_clear_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ref_rise |=> !missing);

  // R6: flag stays up until an edge arrives
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (missing && !ref_rise) |=> missing);

endmodule

// File: rtl/pps_result_stage.sv
module pps_result_stage #(
  parameter int CNT_W        = 28,
  parameter int PERIOD_TICKS = 100_000_000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic signed [CNT_W-1:0] load_data,
  input  logic                    ready,
  output logic                    valid,
  output logic signed [CNT_W-1:0] data
);
  localparam int HALF = PERIOD_TICKS / 2;
  localparam int LOW  = PERIOD_TICKS - HALF;

  // Latest wins: a new word overwrites one still waiting.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= load_data;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  // R8: a stalled word holds
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && !load) |=> (valid && $stable(data)));

  // R8: an accepted word retires
  a_r8_retire: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ready && !load) |=> !valid);

  // R1: reported words lie within the wrapped range
  a_r1_range: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (int'(data) >= -LOW && int'(data) < HALF));

endmodule

// File: rtl/pps_phase_detector.sv
module pps_phase_detector
  import pps_pd_pkg::*;
#(
  parameter int CNT_W        = 28,
  parameter int PERIOD_TICKS = 100_000_000,
  parameter int MISS_TICKS   = 150_000_000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ref_pps_i,
  input  logic                    loc_pps_i,
  input  logic [1:0]              mode_sel_i,
  input  logic                    err_ready_i,
  output logic                    err_valid_o,
  output logic signed [CNT_W-1:0] err_data_o,
  output logic                    missing_o,
  output logic [1:0]              active_mode_o
);
  localparam logic [CNT_W-1:0] HALF_C   = CNT_W'(PERIOD_TICKS / 2);
  localparam logic [CNT_W-1:0] PERIOD_C = CNT_W'(PERIOD_TICKS);

  logic ref_rise, loc_rise, seen, fire;
  logic [CNT_W-1:0] offset;
  logic signed [CNT_W-1:0] err_val;

  // Both pulses take the same synchronizer path so their skew cancels.
  pps_edge_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
    .clk(clk), .rst_n(rst_n), .din(ref_pps_i), .rise(ref_rise));

  pps_edge_sync #(.STAGES(SYNC_STAGES)) u_loc_sync (
    .clk(clk), .rst_n(rst_n), .din(loc_pps_i), .rise(loc_rise));

  pps_offset_counter #(.CNT_W(CNT_W), .PERIOD_TICKS(PERIOD_TICKS)) u_offset (
    .clk(clk), .rst_n(rst_n), .loc_rise(loc_rise), .offset(offset), .seen(seen));

  pps_miss_watch #(.MISS_TICKS(MISS_TICKS)) u_miss (
    .clk(clk), .rst_n(rst_n), .ref_rise(ref_rise), .missing(missing_o));

  // Fold the count onto the nearer local pulse.
  always_comb begin
    if (offset < HALF_C) err_val = signed'(offset);
    else                 err_val = signed'(offset - PERIOD_C);
  end

  assign fire = ref_rise && (mode_sel_i == MODE_PPS) && seen && !missing_o;

  pps_result_stage #(.CNT_W(CNT_W), .PERIOD_TICKS(PERIOD_TICKS)) u_result (
    .clk(clk), .rst_n(rst_n), .load(fire), .load_data(err_val),
    .ready(err_ready_i), .valid(err_valid_o), .data(err_data_o));

  always_ff @(posedge clk) begin
    if (!rst_n) active_mode_o <= MODE_FREE;
    else        active_mode_o <= report_mode(mode_sel_i);
  end

  // R3: a word only appears after a pulse-lock cycle
  a_r3_lock_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_valid_o) |-> ($past(mode_sel_i) == MODE_PPS));

  // R7: no word from an edge taken while the flag was up
  a_r7_no_word_when_missing: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_valid_o) |-> !$past(missing_o));

  // R5: no word without a prior local edge
  a_r5_needs_local: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_valid_o) |-> $past(seen));

  // R4: reported mode is never the reserved code
  a_r4_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    active_mode_o != MODE_RSVD);

endmodule

// File: tb/test_pps_phase_detector.sv
module test_pps_phase_detector;
  localparam int P = 1000;
  localparam int MISS = 1500;
  localparam int W = 28;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_pps = 1'b0, loc_pps = 1'b0, ready = 1'b1;
  logic [1:0] mode = 2'b10;
  logic valid, missing;
  logic signed [W-1:0] data;
  logic [1:0] amode;

  int checks = 0, fails = 0;
  bit exp_pend = 0;
  int exp_val = 0;
  bit bp_hold = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pps_phase_detector #(.CNT_W(W), .PERIOD_TICKS(P), .MISS_TICKS(MISS)) i_pps_phase_detector (
    .clk(clk), .rst_n(rst_n), .ref_pps_i(ref_pps), .loc_pps_i(loc_pps),
    .mode_sel_i(mode), .err_ready_i(ready), .err_valid_o(valid),
    .err_data_o(data), .missing_o(missing), .active_mode_o(amode));

  function automatic int exp_err(int ds);
    return (ds < P / 2) ? ds : ds - P;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Monitor: handshakes sampled at the falling edge.
  always @(negedge clk) begin
    if (rst_n && valid && ready) begin
      if (!exp_pend) check(1'b0, "R3/R5/R7 unexpected word", int'(data), 0);
      else check(int'(data) == exp_val, "R1 error word", int'(data), exp_val);
      exp_pend = 0;
    end
  end

  // One local period: local pulse at cycle 0, reference at cycle ds.
  task automatic run_window(int ds, bit ext_on, bit loc_on, bit want, int len);
    for (int c = 0; c < len; c++) begin
      @(posedge clk); #1;
      loc_pps = loc_on && (c < 5);
      ref_pps = ext_on && (c >= ds) && (c < ds + 5);
      if (ext_on && c == ds && want) begin
        exp_pend = 1;
        exp_val = exp_err(ds);
      end
      ready = bp_hold ? 1'b0 : (($urandom % 4) != 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int ds, held;
    void'($urandom(32'd4711));
    repeat (8) @(posedge clk);
    #1;
    // R9 reset state
    check(valid == 1'b0, "R9 valid", int'(valid), 0);
    check(data == '0, "R9 data", int'(data), 0);
    check(missing == 1'b0, "R9 missing", int'(missing), 0);
    check(amode == 2'b00, "R9 mode", int'(amode), 0);
    rst_n = 1'b1;

    // R5: reference without any local edge
    run_window(100, 1, 0, 0, P);
    check(valid == 1'b0, "R5 no word before local", int'(valid), 0);

    // R1/R2/R10 directed corners, pulses five cycles wide
    run_window(0, 1, 1, 1, P);
    run_window(1, 1, 1, 1, P);
    run_window(250, 1, 1, 1, P);
    run_window(499, 1, 1, 1, P);
    run_window(500, 1, 1, 1, P);
    run_window(750, 1, 1, 1, P);
    run_window(999, 1, 1, 1, P);
    ds = 400;
    for (int k = 0; k < 15; k++) begin
      int lo, hi;
      lo = (ds - 300 < 10) ? 10 : ds - 300;
      hi = (ds + 300 > 990) ? 990 : ds + 300;
      ds = lo + int'($urandom % (hi - lo + 1));
      run_window(ds, 1, 1, 1, P);
    end
    run_window(100, 1, 1, 1, P);
    check(!exp_pend, "R1 word delivered", int'(exp_pend), 0);

    // R3/R4: frequency lock and free run hold the data
    held = int'(data);
    mode = 2'b01;
    run_window(100, 1, 1, 0, P);
    check(amode == 2'b01, "R4 freq mode", int'(amode), 1);
    run_window(100, 1, 1, 0, P);
    check(int'(data) == held, "R3 data held freq", int'(data), held);
    mode = 2'b11;
    run_window(100, 1, 1, 0, P);
    check(amode == 2'b00, "R4 reserved reports free", int'(amode), 0);
    mode = 2'b00;
    run_window(100, 1, 1, 0, P);
    check(amode == 2'b00, "R4 free mode", int'(amode), 0);
    check(int'(data) == held, "R3 data held free", int'(data), held);
    check(valid == 1'b0, "R3 no valid outside lock", int'(valid), 0);

    // R8: back-pressure, latest wins
    mode = 2'b10;
    bp_hold = 1;
    run_window(100, 1, 1, 1, P);
    check(valid == 1'b1, "R8 valid held", int'(valid), 1);
    check(int'(data) == 100, "R8 first held", int'(data), 100);
    run_window(200, 1, 1, 1, P);
    run_window(300, 1, 1, 1, P);
    check(valid == 1'b1, "R8 valid still held", int'(valid), 1);
    check(int'(data) == 300, "R8 latest wins", int'(data), 300);
    bp_hold = 0;
    run_window(300, 1, 1, 1, P);

    // R6/R7: silent reference
    run_window(0, 1, 1, 1, P);
    run_window(0, 0, 1, 0, 400);
    check(missing == 1'b0, "R6 not yet missing", int'(missing), 0);
    run_window(0, 0, 1, 0, 600);
    check(missing == 1'b1, "R6 missing set", int'(missing), 1);
    run_window(0, 1, 1, 0, P);
    check(missing == 1'b0, "R6 missing cleared", int'(missing), 0);
    check(!exp_pend, "R7 recovery edge no word", int'(exp_pend), 0);
    run_window(0, 1, 1, 1, P);
    run_window(100, 1, 1, 1, 200);
    repeat (20) begin
      @(posedge clk); #1; ready = 1'b1;
    end
    check(!exp_pend, "R2 zero offset delivered", int'(exp_pend), 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule